// File: doc/BRIEF.md
# Dynamic Priority Interrupt Winner Selector

This block picks one interrupt line to report for each of two request classes: the normal class and the fast class. It looks at up to three banks of 32 lines. For each line it has a pending bit, a mask bit, a routing bit that chooses the class, and a priority value. A line takes part in a class's contest only when it is pending, not masked, and routed to that class.

Priority 0 is the most urgent value. When several lines share the best value, the line with the highest index wins. The search runs combinationally over every line at once.

The surrounding controller tells the block when to take a new result. It does this with one load strobe per class. On that strobe, the winning line number of that class is captured in a register, which software then reads. A combinational flag per class reports whether any line is currently eligible for that class. Register access, input capture and output re-arming all belong to the surrounding controller.

Top module: `dyn_prio_arb`

## Requirements
- R1: While reset is asserted and after it is released, both latched winners read 0 until their first load strobe.
- R2: Among the eligible lines of a class, the line with the numerically smallest priority value wins. Value 0 is the most urgent.
- R3: When several eligible lines share the best priority value, the line with the largest line number wins, including across banks.
- R4: A line is eligible for the normal class when its pending bit is 1, its mask bit is 0 and its routing bit is 0.
- R5: A line is eligible for the fast class when its pending bit is 1, its mask bit is 0 and its routing bit is 1.
- R6: The line number reported is 32 × bank + bit position. Line k is bit k of the pending, mask and routing vectors, and its priority is bits [k·PRIO_W +: PRIO_W] of the priority vector.
- R7: A load strobe seen while no line is eligible for that class sets that class's winner to 0.
- R8: Each class's winner changes only on the clock edge at which that class's own strobe is high. In every other cycle it holds its value, whatever the other class's strobe or the inputs do.
- R9: Each class's any-flag is 1 in the same cycle exactly when at least one line is eligible for that class.
- R10: The winner captured on a strobe edge reflects the inputs present at that edge. It is visible at the output right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pend_i | input | 32·NUM_BANKS | Pending bit per line |
| mask_i | input | 32·NUM_BANKS | Mask bit per line; 1 excludes the line |
| route_fiq_i | input | 32·NUM_BANKS | Routing bit per line; 0 = normal class, 1 = fast class |
| prio_i | input | 32·NUM_BANKS·PRIO_W | Priority value per line, packed with line k at [k·PRIO_W +: PRIO_W] |
| load_irq_i | input | 1 | Capture strobe for the normal-class winner |
| load_fiq_i | input | 1 | Capture strobe for the fast-class winner |
| irq_win_o | output | clog2(32·NUM_BANKS) | Latched normal-class winning line number |
| fiq_win_o | output | clog2(32·NUM_BANKS) | Latched fast-class winning line number |
| irq_any_o | output | 1 | Some line is eligible for the normal class |
| fiq_any_o | output | 1 | Some line is eligible for the fast class |

## Verification
The only state in this block is the two winner registers. A wrong captured value shows on the winner output in the first cycle after the faulty strobe edge. It stays there until the next strobe of that class.

A fault in the comparison tree, such as a reversed tie rule, a lost bank, or a wrong class filter, shows up as a wrong line number at the next strobe. A fault in the eligibility logic shows up at once on the any-flag, in the same cycle.

The bench keeps a behavioural model and compares both winners and both flags every cycle. This catches a stray update or a missed hold within one clock.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int BANK_LINES = 32;

    typedef enum logic {
        CLS_IRQ = 1'b0,
        CLS_FIQ = 1'b1
    } cls_e;

    function automatic int lines_for(input int nbanks);
        return nbanks * BANK_LINES;
    endfunction

endpackage

// File: rtl/arb_elig.sv
module arb_elig
    import arb_pkg::*;
#(
    parameter int   LINES = 96,
    parameter cls_e CLS   = CLS_IRQ
) (
    input  logic [LINES-1:0] pend_i,
    input  logic [LINES-1:0] mask_i,
    input  logic [LINES-1:0] route_fiq_i,
    output logic [LINES-1:0] elig_o,
    output logic             any_o
);

    logic [LINES-1:0] routed;

    generate
        if (CLS == CLS_FIQ) begin : g_fast
            assign routed = route_fiq_i;
        end else begin : g_norm
            assign routed = ~route_fiq_i;
        end
    endgenerate

    assign elig_o = pend_i & ~mask_i & routed;
    assign any_o  = |elig_o;

endmodule

// File: rtl/arb_tree.sv
module arb_tree #(
    parameter int LINES  = 96,
    parameter int PRIO_W = 6,
    parameter int IDX_W  = $clog2(LINES)
) (
    input  logic [LINES-1:0]        elig_i,
    input  logic [LINES*PRIO_W-1:0] prio_i,
    output logic                    valid_o,
    output logic [IDX_W-1:0]        idx_o
);

    localparam int LEAVES = 1 << $clog2(LINES);
    localparam int NODES  = 2 * LEAVES - 1;

    typedef struct packed {
        logic              valid;
        logic [PRIO_W-1:0] prio;
        logic [IDX_W-1:0]  idx;
    } cand_t;

    // Left child always holds lower line numbers; on equal priority the right one is kept.
    function automatic cand_t pick(input cand_t lo, input cand_t hi);
        if (hi.valid && (!lo.valid || hi.prio <= lo.prio))
            return hi;
        return lo;
    endfunction

    function automatic cand_t reduce(input logic [LINES-1:0] e,
                                     input logic [LINES*PRIO_W-1:0] p);
        cand_t node [NODES];
        for (int k = 0; k < LEAVES; k++) begin
            if (k < LINES) begin
                node[LEAVES-1+k].valid = e[k];
                node[LEAVES-1+k].prio  = p[k*PRIO_W +: PRIO_W];
                node[LEAVES-1+k].idx   = IDX_W'(k);
            end else begin
                node[LEAVES-1+k] = '0;
            end
        end
        for (int i = LEAVES - 2; i >= 0; i--)
            node[i] = pick(node[2*i+1], node[2*i+2]);
        return node[0];
    endfunction

    cand_t best;

    always_comb begin
        best    = reduce(elig_i, prio_i);
        valid_o = best.valid;
        idx_o   = best.valid ? best.idx : '0;
    end

endmodule

// File: rtl/arb_latch.sv
module arb_latch #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             valid_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [IDX_W-1:0] win_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            win_o <= '0;
        else if (load_i)
            win_o <= valid_i ? idx_i : '0;
    end

endmodule

// File: rtl/dyn_prio_arb.sv
module dyn_prio_arb
    import arb_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int PRIO_W    = 6
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [32*NUM_BANKS-1:0]               pend_i,
    input  logic [32*NUM_BANKS-1:0]               mask_i,
    input  logic [32*NUM_BANKS-1:0]               route_fiq_i,
    input  logic [32*NUM_BANKS*PRIO_W-1:0]        prio_i,
    input  logic                                  load_irq_i,
    input  logic                                  load_fiq_i,
    output logic [$clog2(32*NUM_BANKS)-1:0]       irq_win_o,
    output logic [$clog2(32*NUM_BANKS)-1:0]       fiq_win_o,
    output logic                                  irq_any_o,
    output logic                                  fiq_any_o
);

    localparam int LINES = lines_for(NUM_BANKS);
    localparam int IDX_W = $clog2(LINES);
    localparam int NCLS  = 2;

    logic [NCLS-1:0]  load;
    logic [NCLS-1:0]  any;
    logic [IDX_W-1:0] win [NCLS];

    assign load = {load_fiq_i, load_irq_i};

    generate
        for (genvar c = 0; c < NCLS; c++) begin : g_cls
            logic [LINES-1:0] elig;
            logic             tvalid;
            logic [IDX_W-1:0] tidx;

            arb_elig #(
                .LINES (LINES),
                .CLS   (c == 0 ? CLS_IRQ : CLS_FIQ)
            ) u_elig (
                .pend_i      (pend_i),
                .mask_i      (mask_i),
                .route_fiq_i (route_fiq_i),
                .elig_o      (elig),
                .any_o       (any[c])
            );

            arb_tree #(
                .LINES  (LINES),
                .PRIO_W (PRIO_W),
                .IDX_W  (IDX_W)
            ) u_tree (
                .elig_i  (elig),
                .prio_i  (prio_i),
                .valid_o (tvalid),
                .idx_o   (tidx)
            );

            arb_latch #(
                .IDX_W (IDX_W)
            ) u_latch (
                .clk     (clk),
                .rst_n   (rst_n),
                .load_i  (load[c]),
                .valid_i (tvalid),
                .idx_i   (tidx),
                .win_o   (win[c])
            );
        end
    endgenerate

    assign irq_win_o = win[0];
    assign fiq_win_o = win[1];
    assign irq_any_o = any[0];
    assign fiq_any_o = any[1];

endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
    parameter int NUM_BANKS = 3,
    parameter int PRIO_W    = 6
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [32*NUM_BANKS-1:0]          pend_i,
    input logic [32*NUM_BANKS-1:0]          mask_i,
    input logic [32*NUM_BANKS-1:0]          route_fiq_i,
    input logic [32*NUM_BANKS*PRIO_W-1:0]   prio_i,
    input logic                             load_irq_i,
    input logic                             load_fiq_i,
    input logic [$clog2(32*NUM_BANKS)-1:0]  irq_win_o,
    input logic [$clog2(32*NUM_BANKS)-1:0]  fiq_win_o,
    input logic                             irq_any_o,
    input logic                             fiq_any_o
);

    localparam int LINES = 32 * NUM_BANKS;

    logic [LINES-1:0] snap_n;
    logic [LINES-1:0] snap_f;
    logic [PRIO_W-1:0] prio_unused;

    assign prio_unused = prio_i[PRIO_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_n <= '0;
            snap_f <= '0;
        end else begin
            snap_n <= pend_i & ~mask_i & ~route_fiq_i;
            snap_f <= pend_i & ~mask_i & route_fiq_i;
        end
    end

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_irq_i |=> $stable(irq_win_o));

    p_fiq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_fiq_i |=> $stable(fiq_win_o));

    p_irq_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_irq_i && !irq_any_o) |=> (irq_win_o == '0));

    p_fiq_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fiq_i && !fiq_any_o) |=> (fiq_win_o == '0));

    p_irq_elig_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_irq_i && irq_any_o) |=> snap_n[irq_win_o]);

    p_fiq_elig_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fiq_i && fiq_any_o) |=> snap_f[fiq_win_o]);

    p_any_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_any_o || fiq_any_o) |-> (|(pend_i & ~mask_i)));

endmodule

bind dyn_prio_arb arb_chk #(
    .NUM_BANKS (NUM_BANKS),
    .PRIO_W    (PRIO_W)
) u_chk (.*);

// File: tb/dyn_prio_arb_tb.sv
`timescale 1ns/1ps
module dyn_prio_arb_tb;

    localparam int NB = 3;
    localparam int PW = 6;
    localparam int N  = 32 * NB;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pend = '0;
    logic [N-1:0]  mask = '0;
    logic [N-1:0]  route = '0;
    logic [N*PW-1:0] prio = '0;
    logic          ld_i = 1'b0;
    logic          ld_f = 1'b0;
    logic [IW-1:0] win_i;
    logic [IW-1:0] win_f;
    logic          any_i;
    logic          any_f;

    int checks = 0;
    int errors = 0;
    int exp_i = 0;
    int exp_f = 0;
    int cycles = 0;
    bit done = 1'b0;
    string tag = "R1";

    always #2 clk = ~clk;

    dyn_prio_arb #(.NUM_BANKS(NB), .PRIO_W(PW)) u_dut (
        .clk (clk), .rst_n (rst_n),
        .pend_i (pend), .mask_i (mask), .route_fiq_i (route), .prio_i (prio),
        .load_irq_i (ld_i), .load_fiq_i (ld_f),
        .irq_win_o (win_i), .fiq_win_o (win_f),
        .irq_any_o (any_i), .fiq_any_o (any_f)
    );

    function automatic int ref_win(input bit fast);
        int best = 0;
        int bp = 1 << PW;
        for (int i = 0; i < N; i++) begin
            int p = int'(prio[i*PW +: PW]);
            if (pend[i] && !mask[i] && (route[i] == fast) && p <= bp) begin
                bp = p;
                best = i;
            end
        end
        return best;
    endfunction

    function automatic bit ref_any(input bit fast);
        for (int i = 0; i < N; i++)
            if (pend[i] && !mask[i] && (route[i] == fast)) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(input string t, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
        end
    endtask

    // behavioural reference registers
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_i <= 0;
            exp_f <= 0;
        end else begin
            if (ld_i) exp_i <= ref_win(1'b0);
            if (ld_f) exp_f <= ref_win(1'b1);
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(tag, "irq winner (R8 R10)", int'(win_i), exp_i);
            check(tag, "fiq winner (R8 R10)", int'(win_f), exp_f);
            check(tag, "irq any (R9)", int'(any_i), int'(ref_any(1'b0)));
            check(tag, "fiq any (R9)", int'(any_f), int'(ref_any(1'b1)));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog all actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic set_prio(input int line, input int v);
        prio[line*PW +: PW] = PW'(v);
    endtask

    task automatic clear_all();
        pend = '0; mask = '0; route = '0; prio = '0;
    endtask

    // assumes current time is just after a rising edge
    task automatic pulse(input bit a, input bit b);
        ld_i = a; ld_f = b;
        @(posedge clk); #1;
        ld_i = 1'b0; ld_f = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "irq winner in reset", int'(win_i), 0);
        check("R1", "fiq winner in reset", int'(win_f), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", "irq winner after reset", int'(win_i), 0);
        check("R1", "fiq winner after reset", int'(win_f), 0);

        // R2: smallest value wins
        tag = "R2";
        clear_all();
        pend[3] = 1; set_prio(3, 7);
        pend[40] = 1; set_prio(40, 2);
        pend[80] = 1; set_prio(80, 9);
        check("R10", "winner before strobe edge", int'(win_i), 0);
        pulse(1, 0);
        check("R2", "lowest value wins", int'(win_i), 40);
        check("R10", "visible right after edge", int'(win_i), 40);

        // R3: tie across banks goes to largest line
        tag = "R3";
        clear_all();
        pend[10] = 1; pend[50] = 1; pend[90] = 1;
        set_prio(10, 4); set_prio(50, 4); set_prio(90, 4);
        pulse(1, 0);
        check("R3", "tie highest line", int'(win_i), 90);
        set_prio(10, 3);
        pulse(1, 0);
        check("R3", "lower value beats tie group", int'(win_i), 10);

        // R4 / R5: class routing
        tag = "R5";
        clear_all();
        pend[20] = 1; route[20] = 1; set_prio(20, 1);
        pend[30] = 1; set_prio(30, 0);
        pend[60] = 1; route[60] = 1; set_prio(60, 0); mask[60] = 1;
        pulse(1, 1);
        check("R4", "normal class ignores fast line", int'(win_i), 30);
        check("R5", "fast class ignores normal and masked", int'(win_f), 20);

        // R6: line number encoding
        tag = "R6";
        clear_all();
        pend[69] = 1; set_prio(69, 63);
        pulse(1, 0);
        check("R6", "bank 2 bit 5", int'(win_i), 69);

        // R8: only own strobe updates
        tag = "R8";
        pend[69] = 0; pend[33] = 1; route[33] = 1;
        pulse(0, 1);
        check("R8", "normal holds on fast strobe", int'(win_i), 69);
        check("R8", "fast updates", int'(win_f), 33);
        pend[33] = 0; pend[7] = 1;
        @(posedge clk); #1;
        check("R8", "no strobe keeps value", int'(win_i), 69);

        // R7: nothing eligible
        tag = "R7";
        mask = '1;
        #1;
        check("R9", "any low when all masked", int'(any_i), 0);
        pulse(1, 1);
        check("R7", "empty normal gives 0", int'(win_i), 0);
        check("R7", "empty fast gives 0", int'(win_f), 0);

        // random phase with narrow priority range to force ties
        tag = "R2";
        for (int c = 0; c < 400; c++) begin
            for (int w = 0; w < NB; w++) begin
                pend[w*32 +: 32]  = $urandom() & $urandom();
                mask[w*32 +: 32]  = $urandom() & $urandom() & $urandom();
                route[w*32 +: 32] = $urandom();
            end
            for (int l = 0; l < N; l++) set_prio(l, int'($urandom_range(0, 3)));
            if (c % 50 == 0) pend = '0;
            ld_i = ($urandom_range(0, 2) != 0);
            ld_f = ($urandom_range(0, 2) != 0);
            @(posedge clk); #1;
        end
        ld_i = 1'b0; ld_f = 1'b0;
        @(posedge clk); #1;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule